// File: doc/BRIEF.md
# Stackless UDP Frame Generator

This block turns a stream of payload bytes into complete Ethernet frames that any receiver will accept as UDP datagrams over IPv4. No processor and no protocol stack are involved. When a start pulse arrives, the block captures the payload length and the addressing inputs. It then emits a fixed 42-byte header, followed by exactly that many payload bytes taken from a show-ahead FIFO. The output is a byte stream with valid and ready handshaking, and it carries start-of-frame and end-of-frame flags toward a MAC or network controller.

The IPv4 header checksum is left as zero because the network controller downstream fills it in. The UDP checksum is also zero, which UDP over IPv4 allows. The source IP address, the source port and the port used when none is configured are parameters. The destination addresses and the destination port are inputs, sampled once per frame.

Top module: `udp_frame_gen`

## Requirements
- R1: After reset, `out_valid`, `busy` and `pl_rd` are low, and they stay low until a start is accepted.
- R2: Header bytes 0 to 5 are the destination MAC, sent most significant byte first. Bytes 6 to 11 are the source MAC. Bytes 12 and 13 are 0x08 and 0x00.
- R3: Header bytes 14 to 33 are the IPv4 header, in this order:
  - 0x45;
  - 0x00;
  - total length = L+28, high byte first;
  - 0x00 0x00;
  - flags 0x40 0x00;
  - TTL 0x40;
  - protocol 0x11;
  - checksum 0x00 0x00;
  - source IP (parameter);
  - destination IP.
- R4: Header bytes 34 to 41 are the UDP header: source port (parameter), destination port, length L+8, and checksum 0x0000. Every 16-bit field is sent high byte first.
- R5: A configured destination port of 0 is replaced by the default port parameter, 3001 (0x0BB9).
- R6: The payload length and all configuration inputs are sampled at the accepted start. Changing them during a frame has no effect on that frame.
- R7: A start pulse while `busy` is high is ignored, and the running frame completes unchanged.
- R8: While `out_ready` is low during the header, `out_valid` stays high and `out_data` holds its value.
- R9: During the payload, `out_valid` follows `pl_valid`, `out_data` equals `pl_data`, and `pl_rd` is high exactly when `pl_valid` and `out_ready` are both high.
- R10: `out_sof` marks header byte 0 and `out_eof` marks the last payload byte. `busy` is low in the cycle after that byte is accepted.
- R11: A start with a payload length of 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, accepted only when idle |
| pay_len | input | LEN_W | Payload length in bytes, L |
| cfg_dst_mac | input | 48 | Destination MAC address |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_dst_ip | input | 32 | Destination IPv4 address |
| cfg_dst_port | input | 16 | Destination UDP port, 0 selects the default |
| pl_data | input | 8 | Payload byte at the FIFO head |
| pl_valid | input | 1 | FIFO not empty |
| pl_rd | output | 1 | Pops the FIFO head |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| busy | output | 1 | A frame is in progress |

## Verification
The embedded properties assume the FIFO behaves as show-ahead. That is, `pl_data` is meaningful whenever `pl_valid` is high, and the FIFO removes its head only on `pl_rd`. The bench models the FIFO as a queue, pops it only on cycles where it sees `pl_rd`, and raises `pl_valid` only while the queue holds data.

The properties also assume that `start` may arrive at any time. The stimulus therefore deliberately pulses it mid-frame and with a zero length. `out_ready` and `pl_valid` are driven with independent gap patterns, so stalls in the header and in the payload are both exercised.

// File: rtl/udpgen_pkg.sv
package udpgen_pkg;
   localparam int ETH_BYTES = 14;
   localparam int IP_BYTES  = 20;
   localparam int UDP_BYTES = 8;
   localparam int HDR_BYTES = ETH_BYTES + IP_BYTES + UDP_BYTES;
   localparam int IDX_W     = $clog2(HDR_BYTES);

   typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} gen_state_t;

   typedef struct packed {
      logic [47:0] dst_mac;
      logic [47:0] src_mac;
      logic [31:0] dst_ip;
      logic [15:0] dst_port;
   } frame_cfg_t;
endpackage

// File: rtl/udpgen_hdr.sv
module udpgen_hdr
   import udpgen_pkg::*;
#(
   parameter int          LEN_W    = 11,
   parameter logic [31:0] SRC_IP   = 32'hC0A8_0A02,
   parameter logic [15:0] SRC_PORT = 16'd5000,
   parameter logic [15:0] DEF_PORT = 16'd3001,
   parameter bit          SET_DF   = 1'b1
) (
   input  frame_cfg_t       cfg,
   input  logic [LEN_W-1:0] len,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o
);
   localparam logic [15:0] IP_OVH  = 16'(IP_BYTES + UDP_BYTES);
   localparam logic [15:0] UDP_OVH = 16'(UDP_BYTES);

   logic [7:0]  hb [HDR_BYTES];
   logic [7:0]  flags_hi;
   logic [15:0] ip_len, udp_len, port_eff;

   generate
      if (SET_DF) begin : g_df
         assign flags_hi = 8'h40;
      end else begin : g_nodf
         assign flags_hi = 8'h00;
      end
   endgenerate

   assign ip_len   = 16'(len) + IP_OVH;
   assign udp_len  = 16'(len) + UDP_OVH;
   assign port_eff = (cfg.dst_port == 16'd0) ? DEF_PORT : cfg.dst_port;

   always_comb begin
      for (int k = 0; k < 6; k++) begin
         hb[k]     = cfg.dst_mac[8*(5-k) +: 8];
         hb[6 + k] = cfg.src_mac[8*(5-k) +: 8];
      end
      hb[12] = 8'h08;
      hb[13] = 8'h00;
      hb[14] = 8'h45;
      hb[15] = 8'h00;
      hb[16] = ip_len[15:8];
      hb[17] = ip_len[7:0];
      hb[18] = 8'h00;
      hb[19] = 8'h00;
      hb[20] = flags_hi;
      hb[21] = 8'h00;
      hb[22] = 8'h40;
      hb[23] = 8'h11;
      hb[24] = 8'h00;
      hb[25] = 8'h00;
      for (int k = 0; k < 4; k++) begin
         hb[26 + k] = SRC_IP[8*(3-k) +: 8];
         hb[30 + k] = cfg.dst_ip[8*(3-k) +: 8];
      end
      hb[34] = SRC_PORT[15:8];
      hb[35] = SRC_PORT[7:0];
      hb[36] = port_eff[15:8];
      hb[37] = port_eff[7:0];
      hb[38] = udp_len[15:8];
      hb[39] = udp_len[7:0];
      hb[40] = 8'h00;
      hb[41] = 8'h00;
   end

   assign byte_o = hb[idx];
endmodule

// File: rtl/udpgen_seq.sv
module udpgen_seq
   import udpgen_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len_in,
   input  logic             out_ready,
   input  logic             pl_valid,
   output gen_state_t       state,
   output logic [IDX_W-1:0] idx,
   output logic [LEN_W-1:0] len_q,
   output logic             accept,
   output logic             busy,
   output logic             out_valid,
   output logic             out_sof,
   output logic             out_eof,
   output logic             pl_rd
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

   logic [LEN_W-1:0] cnt;
   logic             last_pay;

   assign accept    = (state == ST_IDLE) && start && (len_in != '0);
   assign busy      = (state != ST_IDLE);
   assign last_pay  = (cnt == len_q - LEN_W'(1));
   assign out_valid = (state == ST_HDR) || ((state == ST_PAY) && pl_valid);
   assign out_sof   = (state == ST_HDR) && (idx == '0);
   assign out_eof   = (state == ST_PAY) && pl_valid && last_pay;
   assign pl_rd     = (state == ST_PAY) && pl_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         cnt   <= '0;
         len_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               state <= ST_HDR;
               idx   <= '0;
               cnt   <= '0;
               len_q <= len_in;
            end
            ST_HDR: if (out_ready) begin
               if (idx == LAST_IDX) state <= ST_PAY;
               else                 idx   <= idx + IDX_W'(1);
            end
            ST_PAY: if (pl_valid && out_ready) begin
               if (last_pay) state <= ST_IDLE;
               else          cnt   <= cnt + LEN_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R8: a stalled header byte keeps its position
   assert_hdr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HDR && !out_ready) |=> (state == ST_HDR && $stable(idx)));
   // R9: FIFO pops only on an accepted byte
   assert_pop_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pl_rd |-> (out_valid && out_ready && pl_valid));
   // R10: block idles right after the last byte
   assert_eof_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_eof && out_ready) |=> !busy);
   assert_sof_eof_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_sof, out_eof}));
   // R7: start while busy does not reload the length
   assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(len_q));
   // R11: zero-length start is ignored
   assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && len_in == '0) |=> !busy);
endmodule

// File: rtl/udp_frame_gen.sv
module udp_frame_gen
   import udpgen_pkg::*;
#(
   parameter int          LEN_W    = 11,
   parameter logic [31:0] SRC_IP   = 32'hC0A8_0A02,
   parameter logic [15:0] SRC_PORT = 16'd5000,
   parameter logic [15:0] DEF_PORT = 16'd3001,
   parameter bit          SET_DF   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] pay_len,
   input  logic [47:0]      cfg_dst_mac,
   input  logic [47:0]      cfg_src_mac,
   input  logic [31:0]      cfg_dst_ip,
   input  logic [15:0]      cfg_dst_port,
   input  logic [7:0]       pl_data,
   input  logic             pl_valid,
   output logic             pl_rd,
   output logic [7:0]       out_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_sof,
   output logic             out_eof,
   output logic             busy
);
   generate
      if (LEN_W < 1 || LEN_W > 15) begin : g_bad_len
         $error("LEN_W must lie in 1..15 so the IPv4 length fits 16 bits");
      end
      if (DEF_PORT == 16'd0) begin : g_bad_port
         $error("DEF_PORT must be nonzero");
      end
   endgenerate

   gen_state_t       state;
   logic [IDX_W-1:0] idx;
   logic [LEN_W-1:0] len_q;
   logic             accept;
   logic [7:0]       hdr_byte;
   frame_cfg_t       cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else if (accept)
         cfg_q <= '{dst_mac: cfg_dst_mac, src_mac: cfg_src_mac,
                    dst_ip: cfg_dst_ip, dst_port: cfg_dst_port};
   end

   udpgen_seq #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .len_in(pay_len),
      .out_ready(out_ready), .pl_valid(pl_valid), .state(state), .idx(idx),
      .len_q(len_q), .accept(accept), .busy(busy), .out_valid(out_valid),
      .out_sof(out_sof), .out_eof(out_eof), .pl_rd(pl_rd)
   );

   udpgen_hdr #(.LEN_W(LEN_W), .SRC_IP(SRC_IP), .SRC_PORT(SRC_PORT),
                .DEF_PORT(DEF_PORT), .SET_DF(SET_DF)) u_hdr (
      .cfg(cfg_q), .len(len_q), .idx(idx), .byte_o(hdr_byte)
   );

   assign out_data = (state == ST_HDR) ? hdr_byte : pl_data;

   // R6: captured configuration is frozen for the whole frame
   assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !accept) |=> (busy |-> $stable(cfg_q)));
   // R9: payload bytes pass straight from the FIFO
   assert_pay_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PAY && pl_valid) |-> (out_data == pl_data && out_valid));
endmodule

// File: tb/sim_udp_frame_gen.sv
module sim_udp_frame_gen;
   localparam int LEN_W = 11;
   localparam logic [31:0] SRC_IP = 32'hC0A8_0A02;
   localparam logic [15:0] SRC_PORT = 16'd5000;

   logic clk = 0, rst_n = 0, start = 0, pl_valid = 0, out_ready = 0;
   logic [LEN_W-1:0] pay_len = '0;
   logic [47:0] cfg_dst_mac = '0, cfg_src_mac = '0;
   logic [31:0] cfg_dst_ip = '0;
   logic [15:0] cfg_dst_port = '0;
   logic [7:0]  pl_data = '0, out_data;
   logic pl_rd, out_valid, out_sof, out_eof, busy;

   int n_run = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];
   logic [7:0] fifo[$];

   always #5 clk = ~clk;

   udp_frame_gen #(.LEN_W(LEN_W), .SRC_IP(SRC_IP), .SRC_PORT(SRC_PORT)) u0 (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic build(input int len, input logic [47:0] dm, input logic [47:0] sm,
                        input logic [31:0] dip, input logic [15:0] dport);
      logic [15:0] p, il, ul;
      p  = (dport == 0) ? 16'd3001 : dport;   // R5
      il = 16'(len + 28);
      ul = 16'(len + 8);
      exp_q.delete();
      for (int k = 5; k >= 0; k--) exp_q.push_back(dm[8*k +: 8]);
      for (int k = 5; k >= 0; k--) exp_q.push_back(sm[8*k +: 8]);
      exp_q.push_back(8'h08); exp_q.push_back(8'h00);
      exp_q.push_back(8'h45); exp_q.push_back(8'h00);
      exp_q.push_back(il[15:8]); exp_q.push_back(il[7:0]);
      exp_q.push_back(8'h00); exp_q.push_back(8'h00);
      exp_q.push_back(8'h40); exp_q.push_back(8'h00);
      exp_q.push_back(8'h40); exp_q.push_back(8'h11);
      exp_q.push_back(8'h00); exp_q.push_back(8'h00);
      for (int k = 3; k >= 0; k--) exp_q.push_back(SRC_IP[8*k +: 8]);
      for (int k = 3; k >= 0; k--) exp_q.push_back(dip[8*k +: 8]);
      exp_q.push_back(SRC_PORT[15:8]); exp_q.push_back(SRC_PORT[7:0]);
      exp_q.push_back(p[15:8]); exp_q.push_back(p[7:0]);
      exp_q.push_back(ul[15:8]); exp_q.push_back(ul[7:0]);
      exp_q.push_back(8'h00); exp_q.push_back(8'h00);
      for (int k = 0; k < len; k++) begin
         exp_q.push_back(8'(len * 3 + k * 7));
         fifo.push_back(8'(len * 3 + k * 7));
      end
   endtask

   task automatic run_frame(input int len, input logic [15:0] dport,
                            input int rmode, input int gmode, input bit disturb);
      int i, cyc, tot;
      bit rdy, plv, hdr, ev, xfer;
      string tag;
      @(negedge clk);
      cfg_dst_mac = 48'h02AA_BB00_0000 + 48'(len); cfg_src_mac = 48'h0211_2233_4455;
      cfg_dst_ip = 32'h0A00_0000 + 32'(len); cfg_dst_port = dport;
      pay_len = LEN_W'(len); start = 1;
      fifo.delete();
      build(len, cfg_dst_mac, cfg_src_mac, cfg_dst_ip, dport);
      tot = exp_q.size();
      @(posedge clk);
      i = 0; cyc = 0;
      while (i < tot && cyc < 5000) begin
         @(negedge clk);
         start = 0;
         if (disturb && cyc == 3) begin   // R6, R7: mid-frame start and config change
            start = 1; pay_len = 7; cfg_dst_ip = 32'hFFFF_0000; cfg_dst_port = 16'h0101;
            cfg_dst_mac = 48'h0; pl_valid = 0;
         end
         rdy = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
         plv = (fifo.size() > 0) && ((gmode == 0) ? 1'b1 : ((cyc % 4) != 2));
         out_ready = rdy; pl_valid = plv; pl_data = plv ? fifo[0] : 8'h00;
         #1;
         hdr = (i < 42);
         ev  = hdr ? 1'b1 : plv;
         tag = (i < 14) ? "R2" : (i < 34) ? "R3" : (i < 42) ? "R4" : "R9";
         chk(out_valid == ev, hdr ? "R8 valid in header" : "R9 valid follows fifo",
             int'(out_valid), int'(ev));
         if (ev) begin
            chk(out_data == exp_q[i], (i == 36 || i == 37) ? "R5/R4 port byte" :
                (disturb ? {tag, " R6 frozen cfg"} : tag), int'(out_data), int'(exp_q[i]));
            chk(out_sof == (i == 0), "R10 sof", int'(out_sof), int'(i == 0));
            chk(out_eof == (i == tot - 1), "R10 eof", int'(out_eof), int'(i == tot - 1));
         end
         chk(pl_rd == (!hdr && plv && rdy), "R9 pl_rd", int'(pl_rd), int'(!hdr && plv && rdy));
         xfer = ev && rdy;
         @(posedge clk);
         if (xfer) begin
            if (!hdr) void'(fifo.pop_front());
            i++;
         end
         cyc++;
      end
      @(negedge clk);
      start = 0; out_ready = 1; pl_valid = 0;
      #1;
      chk(busy == 0, disturb ? "R7 no restart after eof" : "R10 idle after eof", int'(busy), 0);
      chk(out_valid == 0, "R10 no output after eof", int'(out_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1; #1;
      chk(out_valid == 0 && busy == 0 && pl_rd == 0, "R1 reset state",
          int'({out_valid, busy, pl_rd}), 0);
      @(negedge clk); #1;
      chk(busy == 0, "R1 stays idle", int'(busy), 0);
      run_frame(1, 16'd0, 0, 0, 0);          // R5 default port, single byte
      run_frame(5, 16'h1234, 1, 1, 0);       // R8 stalls, R9 gaps
      run_frame(20, 16'd0, 1, 0, 1);         // R6, R7 disturbances
      run_frame(3, 16'hBEEF, 0, 1, 0);
      @(negedge clk);
      pay_len = '0; start = 1;                 // R11 zero length
      @(negedge clk); start = 0; #1;
      chk(busy == 0 && out_valid == 0, "R11 zero length ignored", int'(busy), 0);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule